// File: doc/BRIEF.md
# SPI-to-I2C Command Bridge

This block sits behind an SPI slave byte receiver. It turns command frames from an SPI host into transactions on a byte-level I2C master engine. A frame is framed by chip select. The block collects the whole frame, checks it, and only then drives the I2C engine through a request/response handshake. Write data from the frame is staged in a local buffer before the bus is touched. Read data returned by the bus is kept in a receive buffer that the host fetches later.

When a transaction or a rejected frame finishes, an active-low interrupt goes low and a status register records the result. The interrupt is released when the host opens its next frame. While a transaction is running, any frame that completes is discarded. A host that wants read data must fetch it before issuing another read, because each read overwrites the buffer from index 0.

Top module: `spi_i2c_bridge`

## Requirements
- R1: After reset, irq_no is high, the receive-count register (reg address 0x06) and the status register (reg address 0x07) read 0x00, and no I2C request is raised.
- R2: A frame of command 0x00, count N, address byte A and exactly N data bytes produces, in order, START carrying A (op 0), N WRITE requests (op 1) carrying the data bytes in frame order with last=0, then STOP (op 3).
- R3: A frame of exactly three bytes, command 0x01, count N and address A, produces START carrying A, then N READ requests (op 2, data 0) with last=1 only on the N-th, then STOP; the k-th returned byte is stored at receive-buffer index k-1.
- R4: A write frame whose data-byte total differs from its count, a read frame not exactly three bytes long, or either with count 0, raises no I2C request, sets status to 0x03 and drives irq_no low.
- R5: No I2C request is raised before chip select (spi_cs_ni) returns high at the end of a frame.
- R6: After the STOP response, status becomes 0x00 on success, 0x01 if START got a NACK (STOP follows at once), or 0x02 if a data WRITE got a NACK (STOP follows at once), and irq_no is low from the next cycle.
- R7: A frame that ends while a transaction is in progress is dropped: it raises no request and does not alter the staged write data of the running transaction.
- R8: irq_no returns high in the cycle after spi_cs_ni falls, except when a STOP response completes in that same cycle, in which case irq_no stays low.
- R9: A raised I2C request keeps its op, data and last values until it is accepted with i2c_req_ready_i.
- R10: Reg address 0x06 returns the byte count of the last completed read (0x00 when its START was NACKed); 0x07 returns status; other addresses return 0x00; write commands leave 0x06 unchanged.
- R11: A second read overwrites only indices 0 to N-1 of the receive buffer; bytes beyond them keep their earlier values.
- R12: A frame whose first byte is neither 0x00 nor 0x01 is ignored: no request, no status change, no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_cs_ni | input | 1 | SPI chip select, active low; frame boundaries |
| spi_rx_valid_i | input | 1 | A received SPI byte is present this cycle |
| spi_rx_data_i | input | 8 | Received SPI byte |
| reg_addr_i | input | 8 | Register read address |
| reg_rdata_o | output | 8 | Register read data |
| buf_raddr_i | input | AW | Receive buffer read index |
| buf_rdata_o | output | 8 | Receive buffer read data |
| i2c_req_valid_o | output | 1 | I2C request pending |
| i2c_req_ready_i | input | 1 | I2C engine accepts the request |
| i2c_req_op_o | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| i2c_req_data_o | output | 8 | Address byte for START, data byte for WRITE |
| i2c_req_last_o | output | 1 | Final READ of the transaction |
| i2c_rsp_valid_i | input | 1 | Response to the accepted request |
| i2c_rsp_nack_i | input | 1 | Response was a NACK |
| i2c_rsp_data_i | input | 8 | Byte returned by a READ |
| irq_no | output | 1 | Completion interrupt, active low |

## Verification
The completion of a transaction, which sets the interrupt, can fall in the same cycle as the start of the next SPI frame, which clears it. The bench holds back the STOP response until the host is ready to open a frame, then drives both in the same cycle. It expects irq_no to stay low, because setting takes priority over clearing. A second overlap, a frame ending while a transaction runs, is provoked by sending a write frame during slow bus responses. It is judged by the scoreboard seeing only the first transaction's data.

// File: rtl/sib_pkg.sv
package sib_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } i2c_op_e;

  localparam logic [7:0] CMD_WR = 8'h00;
  localparam logic [7:0] CMD_RD = 8'h01;

  localparam logic [7:0] ST_OK        = 8'h00;
  localparam logic [7:0] ST_ADDR_NACK = 8'h01;
  localparam logic [7:0] ST_DATA_NACK = 8'h02;
  localparam logic [7:0] ST_FRAME_ERR = 8'h03;

  localparam logic [7:0] REG_RXCNT  = 8'h06;
  localparam logic [7:0] REG_STATUS = 8'h07;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] len;
  } xfer_t;
endpackage

// File: rtl/sib_frame_parser.sv
module sib_frame_parser
  import sib_pkg::*;
#(
  parameter int unsigned DEPTH = 255,
  parameter int unsigned AW    = 8,
  parameter int unsigned IW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          busy_i,
  output logic          frame_start_o,
  output logic          go_wr_o,
  output logic          go_rd_o,
  output logic          go_bad_o,
  output xfer_t         xfer_o,
  output logic          stg_we_o,
  output logic [AW-1:0] stg_waddr_o,
  output logic [7:0]    stg_wdata_o
);
  localparam logic [IW-1:0] HDR_LEN = IW'(3);
  localparam logic [IW-1:0] IDX_MAX = '1;

  logic          cs_q;
  logic [IW-1:0] idx_q;
  logic [7:0]    cmd_q, cnt_q, addr_q;
  logic          frame_end, take;
  logic [IW-1:0] data_off;
  logic          is_wr, is_rd, cnt_ok, wr_ok, rd_ok;

  assign frame_start_o = cs_q & ~cs_ni;
  assign frame_end     = ~cs_q & cs_ni;
  assign take          = rx_valid_i & ~cs_ni;
  assign data_off      = idx_q - HDR_LEN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      idx_q  <= '0;
      cmd_q  <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      cs_q <= cs_ni;
      if (frame_end) begin
        idx_q <= '0;
      end else if (take) begin
        if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
        if (idx_q == IW'(0)) cmd_q  <= rx_data_i;
        if (idx_q == IW'(1)) cnt_q  <= rx_data_i;
        if (idx_q == IW'(2)) addr_q <= rx_data_i;
      end
    end
  end

  // staging is frozen while a transaction reads it
  assign stg_we_o    = take & (idx_q >= HDR_LEN) & (int'(data_off) < DEPTH) & ~busy_i;
  assign stg_waddr_o = data_off[AW-1:0];
  assign stg_wdata_o = rx_data_i;

  assign is_wr  = (idx_q != '0) & (cmd_q == CMD_WR);
  assign is_rd  = (idx_q != '0) & (cmd_q == CMD_RD);
  assign cnt_ok = (cnt_q != 8'd0);
  assign wr_ok  = is_wr & cnt_ok & (idx_q == (IW'(cnt_q) + HDR_LEN));
  assign rd_ok  = is_rd & cnt_ok & (idx_q == HDR_LEN);

  assign go_wr_o  = frame_end & ~busy_i & wr_ok;
  assign go_rd_o  = frame_end & ~busy_i & rd_ok;
  assign go_bad_o = frame_end & ~busy_i & (is_wr | is_rd) & ~(wr_ok | rd_ok);

  assign xfer_o.addr = addr_q;
  assign xfer_o.len  = cnt_q;
endmodule

// File: rtl/sib_byte_buf.sv
module sib_byte_buf #(
  parameter int unsigned DEPTH = 255,
  parameter int unsigned AW    = 8,
  parameter int unsigned W     = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(waddr_i) < DEPTH)) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem[raddr_i] : '0;
endmodule

// File: rtl/sib_i2c_seq.sv
module sib_i2c_seq
  import sib_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_wr_i,
  input  logic          go_rd_i,
  input  xfer_t         xfer_i,
  output logic [AW-1:0] tx_raddr_o,
  input  logic [7:0]    tx_rdata_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output i2c_op_e       req_op_o,
  output logic [7:0]    req_data_o,
  output logic          req_last_o,
  input  logic          rsp_valid_i,
  input  logic          rsp_nack_i,
  input  logic [7:0]    rsp_data_i,
  output logic          rx_we_o,
  output logic [AW-1:0] rx_waddr_o,
  output logic [7:0]    rx_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [7:0]    done_status_o,
  output logic [7:0]    rx_count_o
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WDAT, S_RDAT, S_STOP} state_e;

  state_e     state_q;
  logic       wait_q, is_rd_q;
  logic [7:0] addr_q, len_q, bidx_q, res_q, rxcnt_q;
  logic       rsp_fire, at_last;

  assign busy_o      = (state_q != S_IDLE);
  assign req_valid_o = busy_o & ~wait_q;
  assign rsp_fire    = wait_q & rsp_valid_i;
  assign at_last     = (bidx_q == len_q - 8'd1);

  always_comb begin
    req_op_o   = OP_STOP;
    req_data_o = 8'h00;
    case (state_q)
      S_ADDR: begin req_op_o = OP_START; req_data_o = addr_q;     end
      S_WDAT: begin req_op_o = OP_WRITE; req_data_o = tx_rdata_i; end
      S_RDAT: req_op_o = OP_READ;
      default: req_op_o = OP_STOP;
    endcase
  end

  assign req_last_o    = (state_q == S_RDAT) & at_last;
  assign tx_raddr_o    = AW'(bidx_q);
  assign rx_we_o       = rsp_fire & (state_q == S_RDAT);
  assign rx_waddr_o    = AW'(bidx_q);
  assign rx_wdata_o    = rsp_data_i;
  assign done_o        = rsp_fire & (state_q == S_STOP);
  assign done_status_o = res_q;
  assign rx_count_o    = rxcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      wait_q  <= 1'b0;
      is_rd_q <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      bidx_q  <= '0;
      res_q   <= ST_OK;
      rxcnt_q <= '0;
    end else if (state_q == S_IDLE) begin
      if (go_wr_i || go_rd_i) begin
        state_q <= S_ADDR;
        wait_q  <= 1'b0;
        is_rd_q <= go_rd_i;
        addr_q  <= xfer_i.addr;
        len_q   <= xfer_i.len;
        bidx_q  <= '0;
        res_q   <= ST_OK;
      end
    end else if (req_valid_o && req_ready_i) begin
      wait_q <= 1'b1;
    end else if (rsp_fire) begin
      wait_q <= 1'b0;
      case (state_q)
        S_ADDR: begin
          if (rsp_nack_i) begin
            res_q   <= ST_ADDR_NACK;
            state_q <= S_STOP;
            if (is_rd_q) rxcnt_q <= 8'd0;
          end else begin
            state_q <= is_rd_q ? S_RDAT : S_WDAT;
          end
        end
        S_WDAT: begin
          if (rsp_nack_i) begin
            res_q   <= ST_DATA_NACK;
            state_q <= S_STOP;
          end else if (at_last) begin
            state_q <= S_STOP;
          end else begin
            bidx_q <= bidx_q + 8'd1;
          end
        end
        S_RDAT: begin
          if (at_last) begin
            state_q <= S_STOP;
            rxcnt_q <= len_q;
          end else begin
            bidx_q <= bidx_q + 8'd1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_i2c_bridge.sv
module spi_i2c_bridge
  import sib_pkg::*;
#(
  parameter  int unsigned BUF_DEPTH = 255,
  localparam int unsigned AW        = $clog2(BUF_DEPTH),
  localparam int unsigned IW        = $clog2(BUF_DEPTH + 4) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          spi_cs_ni,
  input  logic          spi_rx_valid_i,
  input  logic [7:0]    spi_rx_data_i,
  input  logic [7:0]    reg_addr_i,
  output logic [7:0]    reg_rdata_o,
  input  logic [AW-1:0] buf_raddr_i,
  output logic [7:0]    buf_rdata_o,
  output logic          i2c_req_valid_o,
  input  logic          i2c_req_ready_i,
  output logic [1:0]    i2c_req_op_o,
  output logic [7:0]    i2c_req_data_o,
  output logic          i2c_req_last_o,
  input  logic          i2c_rsp_valid_i,
  input  logic          i2c_rsp_nack_i,
  input  logic [7:0]    i2c_rsp_data_i,
  output logic          irq_no
);
  logic          frame_start, go_wr, go_rd, go_bad;
  xfer_t         xfer;
  logic          stg_we;
  logic [AW-1:0] stg_waddr, tx_raddr, rx_waddr;
  logic [7:0]    stg_wdata, tx_rdata, rx_wdata;
  logic          rx_we, seq_busy, seq_done;
  logic [7:0]    done_status, rx_count;
  i2c_op_e       req_op;
  logic [7:0]    status_q;
  logic          irq_q;

  sib_frame_parser #(.DEPTH(BUF_DEPTH), .AW(AW), .IW(IW)) u_parser (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cs_ni         (spi_cs_ni),
    .rx_valid_i    (spi_rx_valid_i),
    .rx_data_i     (spi_rx_data_i),
    .busy_i        (seq_busy),
    .frame_start_o (frame_start),
    .go_wr_o       (go_wr),
    .go_rd_o       (go_rd),
    .go_bad_o      (go_bad),
    .xfer_o        (xfer),
    .stg_we_o      (stg_we),
    .stg_waddr_o   (stg_waddr),
    .stg_wdata_o   (stg_wdata)
  );

  sib_byte_buf #(.DEPTH(BUF_DEPTH), .AW(AW), .W(8)) u_tx_buf (
    .clk_i   (clk_i),
    .we_i    (stg_we),
    .waddr_i (stg_waddr),
    .wdata_i (stg_wdata),
    .raddr_i (tx_raddr),
    .rdata_o (tx_rdata)
  );

  sib_byte_buf #(.DEPTH(BUF_DEPTH), .AW(AW), .W(8)) u_rx_buf (
    .clk_i   (clk_i),
    .we_i    (rx_we),
    .waddr_i (rx_waddr),
    .wdata_i (rx_wdata),
    .raddr_i (buf_raddr_i),
    .rdata_o (buf_rdata_o)
  );

  sib_i2c_seq #(.AW(AW)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .go_wr_i       (go_wr),
    .go_rd_i       (go_rd),
    .xfer_i        (xfer),
    .tx_raddr_o    (tx_raddr),
    .tx_rdata_i    (tx_rdata),
    .req_valid_o   (i2c_req_valid_o),
    .req_ready_i   (i2c_req_ready_i),
    .req_op_o      (req_op),
    .req_data_o    (i2c_req_data_o),
    .req_last_o    (i2c_req_last_o),
    .rsp_valid_i   (i2c_rsp_valid_i),
    .rsp_nack_i    (i2c_rsp_nack_i),
    .rsp_data_i    (i2c_rsp_data_i),
    .rx_we_o       (rx_we),
    .rx_waddr_o    (rx_waddr),
    .rx_wdata_o    (rx_wdata),
    .busy_o        (seq_busy),
    .done_o        (seq_done),
    .done_status_o (done_status),
    .rx_count_o    (rx_count)
  );

  assign i2c_req_op_o = req_op;

  // completion outranks a clear from a frame opening in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= ST_OK;
      irq_q    <= 1'b0;
    end else begin
      if (seq_done)    status_q <= done_status;
      else if (go_bad) status_q <= ST_FRAME_ERR;
      if (seq_done || go_bad) irq_q <= 1'b1;
      else if (frame_start)   irq_q <= 1'b0;
    end
  end

  assign irq_no = ~irq_q;

  always_comb begin
    case (reg_addr_i)
      REG_RXCNT:  reg_rdata_o = rx_count;
      REG_STATUS: reg_rdata_o = status_q;
      default:    reg_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/sib_chk.sv
module sib_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic [7:0] req_data,
  input logic       req_last,
  input logic       irq_n,
  input logic       busy,
  input logic       done,
  input logic       go_wr,
  input logic       go_rd,
  input logic       go_bad,
  input logic       frame_start
);
  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_data) && $stable(req_last));

  p_irq_on_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !irq_n);

  p_irq_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start && !done && !go_bad |=> irq_n);

  p_drop_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !(go_wr || go_rd));

  p_start_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_wr || go_rd) |=> busy && req_valid && req_op == 2'd0);

  p_bad_no_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_bad |=> !irq_n && !req_valid);
endmodule

bind spi_i2c_bridge sib_chk u_sib_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid   (i2c_req_valid_o),
  .req_ready   (i2c_req_ready_i),
  .req_op      (i2c_req_op_o),
  .req_data    (i2c_req_data_o),
  .req_last    (i2c_req_last_o),
  .irq_n       (irq_no),
  .busy        (seq_busy),
  .done        (seq_done),
  .go_wr       (go_wr),
  .go_rd       (go_rd),
  .go_bad      (go_bad),
  .frame_start (frame_start)
);

// File: tb/test_spi_i2c_bridge.sv
module test_spi_i2c_bridge;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_rdata;
  logic [7:0] buf_raddr = '0;
  logic [7:0] buf_rdata;
  logic       req_valid;
  logic       req_ready = 1'b0;
  logic [1:0] req_op;
  logic [7:0] req_data;
  logic       req_last;
  logic       rsp_valid = 1'b0;
  logic       rsp_nack = 1'b0;
  logic [7:0] rsp_data = '0;
  logic       irq_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_i2c_bridge i_spi_i2c_bridge (
    .clk_i (clk), .rst_ni (rst_n),
    .spi_cs_ni (cs_n), .spi_rx_valid_i (rx_valid), .spi_rx_data_i (rx_data),
    .reg_addr_i (reg_addr), .reg_rdata_o (reg_rdata),
    .buf_raddr_i (buf_raddr), .buf_rdata_o (buf_rdata),
    .i2c_req_valid_o (req_valid), .i2c_req_ready_i (req_ready),
    .i2c_req_op_o (req_op), .i2c_req_data_o (req_data), .i2c_req_last_o (req_last),
    .i2c_rsp_valid_i (rsp_valid), .i2c_rsp_nack_i (rsp_nack), .i2c_rsp_data_i (rsp_data),
    .irq_no (irq_n)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [10:0] exp_q[$];
  logic [7:0]  fb [0:15];
  int  nack_idx = -1;
  int  req_num = 0;
  int  rd_k = 0;
  logic [7:0] rd_base = '0;
  int  rsp_gap = 2;
  int  hold_gap = 0;
  bit  manual_stop = 0;
  bit  stop_pending = 0;
  bit  stop_go = 0;
  logic irq_after_start;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] itm(input logic [1:0] op, input logic [7:0] d, input logic l);
    return {op, d, l};
  endfunction

  task automatic push(input logic [1:0] op, input logic [7:0] d, input logic l);
    exp_q.push_back(itm(op, d, l));
  endtask

  task automatic new_xfer(input int nack_at, input logic [7:0] base);
    nack_idx = nack_at;
    req_num  = 0;
    rd_k     = 0;
    rd_base  = base;
  endtask

  // drives one frame; records irq one cycle after chip select falls
  task automatic send_frame(input int n);
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_data  = fb[i];
      @(negedge clk);
      if (i == 0) irq_after_start = irq_n;
    end
    rx_valid = 1'b0;
    if (n == 0) begin
      @(negedge clk);
      irq_after_start = irq_n;
    end
    cs_n = 1'b1;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (irq_n !== 1'b0 && t < 500) begin
      @(negedge clk);
      t++;
    end
    chk({req, " irq low"}, irq_n, 1'b0);
    repeat (3) @(negedge clk);
    chk({req, " all requests seen"}, exp_q.size(), 0);
  endtask

  task automatic rd_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic rd_buf(input string req, input logic [7:0] a, input logic [7:0] exp);
    buf_raddr = a;
    #1;
    chk(req, buf_rdata, exp);
  endtask

  // I2C engine model and scoreboard monitor
  initial begin
    logic [10:0] got, want;
    forever begin
      @(negedge clk);
      if (req_valid === 1'b1) begin
        got = {req_op, req_data, req_last};
        if (hold_gap > 0) begin
          repeat (hold_gap) @(negedge clk);
          chk("R9 request held until ready", {req_valid, req_op, req_data, req_last}, {1'b1, got});
        end
        req_ready = 1'b1;
        if (exp_q.size() == 0) begin
          n_checks++;
          n_fail++;
          $display("FAIL R2/R3/R7 unexpected request actual=%0h expected=none", got);
        end else begin
          want = exp_q.pop_front();
          chk("R2/R3/R6 request sequence", got, want);
        end
        @(negedge clk);
        req_ready = 1'b0;
        repeat (rsp_gap) @(negedge clk);
        if (got[10:9] == 2'd3 && manual_stop) begin
          stop_pending = 1'b1;
          wait (stop_go);
          @(negedge clk);
          stop_pending = 1'b0;
        end
        rsp_valid = 1'b1;
        rsp_nack  = (req_num == nack_idx);
        rsp_data  = rd_base + 8'(rd_k);
        if (got[10:9] == 2'd2) rd_k++;
        req_num++;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_nack  = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 irq after reset", irq_n, 1'b1);
    chk("R1 no request after reset", req_valid, 1'b0);
    rd_reg("R1 rx count reset", 8'h06, 8'h00);
    rd_reg("R1 status reset", 8'h07, 8'h00);

    // R2/R5/R9: write three bytes, ready delayed
    new_xfer(-1, 8'h00);
    hold_gap = 2;
    push(2'd0, 8'h50, 1'b0);
    push(2'd1, 8'h11, 1'b0);
    push(2'd1, 8'h22, 1'b0);
    push(2'd1, 8'h33, 1'b0);
    push(2'd3, 8'h00, 1'b0);
    fb[0] = 8'h00; fb[1] = 8'h03; fb[2] = 8'h50; fb[3] = 8'h11; fb[4] = 8'h22; fb[5] = 8'h33;
    send_frame(6);
    chk("R5 no request before frame end", req_valid, 1'b0);
    wait_done("R2 write");
    hold_gap = 0;
    rd_reg("R6 status success", 8'h07, 8'h00);

    // R12 unknown command, R8 clear on frame start
    fb[0] = 8'h05; fb[1] = 8'h01; fb[2] = 8'h50;
    send_frame(3);
    chk("R8 irq released after chip select falls", irq_after_start, 1'b1);
    repeat (5) @(negedge clk);
    chk("R12 unknown command no irq", irq_n, 1'b1);
    chk("R12 unknown command no request", exp_q.size(), 0);
    rd_reg("R12 status unchanged", 8'h07, 8'h00);

    // R3: read four bytes
    new_xfer(-1, 8'h10);
    push(2'd0, 8'h51, 1'b0);
    for (int k = 0; k < 4; k++) push(2'd2, 8'h00, k == 3);
    push(2'd3, 8'h00, 1'b0);
    fb[0] = 8'h01; fb[1] = 8'h04; fb[2] = 8'h51;
    send_frame(3);
    wait_done("R3 read");
    rd_reg("R10 rx count after read", 8'h06, 8'h04);
    for (int k = 0; k < 4; k++) rd_buf("R3 read data stored", 8'(k), 8'h10 + 8'(k));

    // R11: second read overwrites the head only
    new_xfer(-1, 8'h50);
    push(2'd0, 8'h51, 1'b0);
    push(2'd2, 8'h00, 1'b0);
    push(2'd2, 8'h00, 1'b1);
    push(2'd3, 8'h00, 1'b0);
    fb[0] = 8'h01; fb[1] = 8'h02; fb[2] = 8'h51;
    send_frame(3);
    wait_done("R11 read");
    rd_reg("R11 rx count replaced", 8'h06, 8'h02);
    rd_buf("R11 index 0 overwritten", 8'd0, 8'h50);
    rd_buf("R11 index 1 overwritten", 8'd1, 8'h51);
    rd_buf("R11 index 2 kept", 8'd2, 8'h12);

    // R4: short write frame
    fb[0] = 8'h00; fb[1] = 8'h02; fb[2] = 8'h50; fb[3] = 8'hAA;
    send_frame(4);
    wait_done("R4 short write");
    rd_reg("R4 status frame error", 8'h07, 8'h03);
    // R4: long write frame after a clean status
    new_xfer(-1, 8'h00);
    push(2'd0, 8'h52, 1'b0);
    push(2'd1, 8'h01, 1'b0);
    push(2'd3, 8'h00, 1'b0);
    fb[0] = 8'h00; fb[1] = 8'h01; fb[2] = 8'h52; fb[3] = 8'h01;
    send_frame(4);
    wait_done("R4 reference write");
    rd_reg("R4 status cleared", 8'h07, 8'h00);
    fb[0] = 8'h00; fb[1] = 8'h01; fb[2] = 8'h52; fb[3] = 8'h01; fb[4] = 8'h02;
    send_frame(5);
    wait_done("R4 long write");
    rd_reg("R4 long write status", 8'h07, 8'h03);
    // R4: read with count 0, read with extra byte
    fb[0] = 8'h01; fb[1] = 8'h00; fb[2] = 8'h52;
    send_frame(3);
    wait_done("R4 read count zero");
    chk("R4 count zero irq was released", irq_after_start, 1'b1);
    rd_reg("R4 read count zero status", 8'h07, 8'h03);
    fb[0] = 8'h01; fb[1] = 8'h02; fb[2] = 8'h52; fb[3] = 8'h00;
    send_frame(4);
    wait_done("R4 read too long");
    rd_reg("R10 rx count untouched by rejected frames", 8'h06, 8'h02);

    // R6: address NACK on write
    new_xfer(0, 8'h00);
    push(2'd0, 8'h60, 1'b0);
    push(2'd3, 8'h00, 1'b0);
    fb[0] = 8'h00; fb[1] = 8'h01; fb[2] = 8'h60; fb[3] = 8'h77;
    send_frame(4);
    wait_done("R6 address nack");
    rd_reg("R6 status address nack", 8'h07, 8'h01);
    rd_reg("R10 write leaves rx count", 8'h06, 8'h02);

    // R6: data NACK on second data byte
    new_xfer(2, 8'h00);
    push(2'd0, 8'h61, 1'b0);
    push(2'd1, 8'hA1, 1'b0);
    push(2'd1, 8'hA2, 1'b0);
    push(2'd3, 8'h00, 1'b0);
    fb[0] = 8'h00; fb[1] = 8'h03; fb[2] = 8'h61; fb[3] = 8'hA1; fb[4] = 8'hA2; fb[5] = 8'hA3;
    send_frame(6);
    wait_done("R6 data nack");
    rd_reg("R6 status data nack", 8'h07, 8'h02);

    // R10: read with address NACK zeroes the count
    new_xfer(0, 8'h00);
    push(2'd0, 8'h62, 1'b0);
    push(2'd3, 8'h00, 1'b0);
    fb[0] = 8'h01; fb[1] = 8'h03; fb[2] = 8'h62;
    send_frame(3);
    wait_done("R10 read address nack");
    rd_reg("R10 rx count zero after nack", 8'h06, 8'h00);
    rd_reg("R6 read address nack status", 8'h07, 8'h01);
    rd_reg("R10 unmapped address", 8'h00, 8'h00);

    // R7: frame arriving while busy is dropped and leaves staging intact
    new_xfer(-1, 8'h00);
    rsp_gap = 6;
    push(2'd0, 8'h63, 1'b0);
    push(2'd1, 8'hB1, 1'b0);
    push(2'd1, 8'hB2, 1'b0);
    push(2'd3, 8'h00, 1'b0);
    fb[0] = 8'h00; fb[1] = 8'h02; fb[2] = 8'h63; fb[3] = 8'hB1; fb[4] = 8'hB2;
    send_frame(5);
    fb[0] = 8'h00; fb[1] = 8'h02; fb[2] = 8'h64; fb[3] = 8'hC1; fb[4] = 8'hC2;
    send_frame(5);
    wait_done("R7 busy drop");
    repeat (20) @(negedge clk);
    chk("R7 no second transaction", req_valid, 1'b0);
    chk("R7 queue empty", exp_q.size(), 0);
    rsp_gap = 2;

    // R8: completion and frame start in the same cycle
    new_xfer(-1, 8'h00);
    manual_stop = 1'b1;
    push(2'd0, 8'h65, 1'b0);
    push(2'd1, 8'hD1, 1'b0);
    push(2'd3, 8'h00, 1'b0);
    fb[0] = 8'h00; fb[1] = 8'h01; fb[2] = 8'h65; fb[3] = 8'hD1;
    send_frame(4);
    wait (stop_pending);
    stop_go = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R8 set wins over same-cycle clear", irq_n, 1'b0);
    @(negedge clk);
    chk("R8 irq stays low during frame", irq_n, 1'b0);
    cs_n = 1'b1;
    stop_go = 1'b0;
    manual_stop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 irq low after empty frame", irq_n, 1'b0);
    rd_reg("R6 status after same-cycle completion", 8'h07, 8'h00);
    chk("R8 queue empty", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule